// File: doc/BRIEF.md
# Memory Request Command Acceptor

This block is the command front end of a memory controller user port. A requester drives an address, a 3-bit operation code and an urgency flag, then raises an enable. The block answers with a ready signal in the same cycle. A request is taken only in a cycle where enable and ready are both high. If ready is low, the requester keeps the request on the bus and tries again.

Ready is the AND of several conditions. The memory must have finished start-up calibration. No periodic read may be in the middle of being inserted. A command slot must be free. The resource that the presented operation needs must also be available: read-buffer space for a read, or a free write-buffer pointer for a write.

Each accepted request has its flat address split into rank, bank, row and column fields. The parameter `MAP` selects one of two bank/row orders for this split. The request is then placed in a first-in first-out slot queue, which a downstream scheduler drains. The queue depth, the field widths, the rank count and the write pointer count are all parameters.

Top module: `mem_cmd_accept`

## Requirements
- R1: Operation code 3'b000 is a write and 3'b001 is a read. Any other code is never accepted, and `cmd_rdy` stays low while such a code is presented.
- R2: A request enters the queue only on a clock edge where both `cmd_en` and `cmd_rdy` are high. One cycle after that edge, `q_valid` is high. A request presented while `cmd_rdy` is low leaves the queue unchanged.
- R3: `cmd_rdy` is low whenever `cal_done` is low.
- R4: `cmd_rdy` is low for every operation while all `DEPTH` queue slots are occupied. It returns high after one entry is popped with `q_pop`.
- R5: While `rd_buf_full` is high, `cmd_rdy` is low for a read and is not affected for a write.
- R6: Each accepted write takes one of `WPTR_COUNT` write pointers, and each `wptr_release` pulse gives one back. With no pointer free, `cmd_rdy` is low for a write but not for a read.
- R7: `cmd_rdy` is low in every cycle in which `periodic_rd` is high.
- R8: With `MAP`=0 (row, bank, column), `q_col` = addr[0 +: COL_W], `q_bank` = addr[COL_W +: BANK_W] and `q_row` = addr[COL_W+BANK_W +: ROW_W].
- R9: With `MAP`=1 (bank, row, column), `q_col` = addr[0 +: COL_W], `q_row` = addr[COL_W +: ROW_W] and `q_bank` = addr[COL_W+ROW_W +: BANK_W].
- R10: With `NUM_RANKS`=1, `q_rank` is 0. Otherwise `q_rank` is taken from the address bits just above the bank and row fields.
- R11: Entries leave the queue in the order they were accepted. Each entry carries its urgency flag unchanged on `q_urgent` and its operation on `q_is_read` (1 for a read).
- R12: A synchronous active-high `rst` empties the queue (`q_valid` low) and frees all write pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_en | input | 1 | Request strobe |
| cmd_op | input | 3 | Operation code (000 write, 001 read) |
| cmd_addr | input | ADDR_W | Flat request address |
| cmd_urgent | input | 1 | High-priority flag |
| cmd_rdy | output | 1 | Request accepted this cycle when `cmd_en` is also high |
| cal_done | input | 1 | Start-up calibration finished |
| rd_buf_full | input | 1 | Read return buffer has no space |
| periodic_rd | input | 1 | Periodic read insertion in progress |
| wptr_release | input | 1 | Returns one write pointer |
| q_valid | output | 1 | Queue head holds an entry |
| q_pop | input | 1 | Removes the head entry |
| q_is_read | output | 1 | Head entry is a read |
| q_urgent | output | 1 | Head entry urgency flag |
| q_rank | output | RANK_W | Head entry rank |
| q_bank | output | BANK_W | Head entry bank |
| q_row | output | ROW_W | Head entry row |
| q_col | output | COL_W | Head entry column |

## Verification
The ready gate is exercised with a table. Each row turns on one blocking condition (calibration pending, read buffer full, periodic insertion, unknown code) and presents it once with a read and once with a write. This separates conditions that block every operation from conditions that block only one.

Directed sequences then do the following:
- Use up the write pointers while queue slots remain free, so a blocked write next to an accepted read shows that pointers are tracked separately from slots.
- Fill the slot queue while a pointer is free, so that slot exhaustion is seen on its own.
- Drain entries with alternating urgency flags, which exposes reordering and lost flags.
- Decode one address on two instances with different field orders and rank counts. Because the bank and row fields sit at different bit positions, a wrong order or a missing rank is visible.

// File: rtl/mca_pkg.sv
package mca_pkg;
   localparam logic [2:0] OP_WRITE = 3'b000;
   localparam logic [2:0] OP_READ  = 3'b001;

   localparam int MAP_ROW_BANK_COL = 0;
   localparam int MAP_BANK_ROW_COL = 1;

   function automatic logic op_known(input logic [2:0] op);
      return (op == OP_WRITE) || (op == OP_READ);
   endfunction

   function automatic int rank_bits(input int ranks);
      return (ranks > 1) ? $clog2(ranks) : 0;
   endfunction
endpackage

// File: rtl/mca_addr_split.sv
module mca_addr_split #(
   parameter int COL_W     = 10,
   parameter int BANK_W    = 3,
   parameter int ROW_W     = 14,
   parameter int NUM_RANKS = 1,
   parameter int MAP       = 0,
   parameter int ADDR_W    = 27,
   parameter int RANK_W    = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [RANK_W-1:0] rank,
   output logic [BANK_W-1:0] bank,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);
   import mca_pkg::*;

   localparam int FIELD_TOP = COL_W + BANK_W + ROW_W;

   if (MAP != MAP_ROW_BANK_COL && MAP != MAP_BANK_ROW_COL) begin : g_bad_map
      $error("mca_addr_split: MAP must be 0 or 1");
   end
   if (ADDR_W < FIELD_TOP + rank_bits(NUM_RANKS)) begin : g_bad_width
      $error("mca_addr_split: ADDR_W too small for the fields");
   end

   assign col = addr[0 +: COL_W];

   if (MAP == MAP_ROW_BANK_COL) begin : g_rbc
      assign bank = addr[COL_W +: BANK_W];
      assign row  = addr[COL_W + BANK_W +: ROW_W];
   end else begin : g_brc
      assign row  = addr[COL_W +: ROW_W];
      assign bank = addr[COL_W + ROW_W +: BANK_W];
   end

   if (NUM_RANKS > 1) begin : g_multi_rank
      assign rank = addr[FIELD_TOP +: RANK_W];
   end else begin : g_one_rank
      assign rank = '0;
   end
endmodule

// File: rtl/mca_slot_fifo.sv
module mca_slot_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("mca_slot_fifo: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [CNT_W-1:0] fill;
   logic             do_pop;

   assign empty  = (fill == '0);
   assign full   = (fill == FULL_CNT);
   assign do_pop = pop && !empty;
   assign dout   = store[rd_idx];

   always_ff @(posedge clk) begin
      if (push) begin
         store[wr_idx] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_idx <= '0;
         rd_idx <= '0;
         fill   <= '0;
      end else begin
         if (push) begin
            wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
         end
         if (do_pop) begin
            rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
         end
         case ({push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      push |-> !full) else $error("slot queue overflow"); // R4

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
      fill <= FULL_CNT) else $error("slot count out of range"); // R4
endmodule

// File: rtl/mca_wptr_pool.sv
module mca_wptr_pool #(
   parameter int COUNT = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic take,
   input  logic give,
   output logic any_free
);
   localparam int FREE_W = $clog2(COUNT + 1);
   localparam logic [FREE_W-1:0] ALL_FREE = FREE_W'(COUNT);

   if (COUNT < 1) begin : g_bad_count
      $error("mca_wptr_pool: COUNT must be at least 1");
   end

   logic [FREE_W-1:0] free_q;
   logic              give_ok;

   // A return with nothing outstanding is dropped
   assign give_ok  = give && (free_q != ALL_FREE);
   assign any_free = (free_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         free_q <= ALL_FREE;
      end else begin
         case ({take, give_ok})
            2'b10:   free_q <= free_q - 1'b1;
            2'b01:   free_q <= free_q + 1'b1;
            default: free_q <= free_q;
         endcase
      end
   end

   AST_POOL_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      take |-> (free_q != '0)) else $error("write pointer taken while none free"); // R6

   AST_POOL_BOUND: assert property (@(posedge clk) disable iff (rst)
      free_q <= ALL_FREE) else $error("write pointer count above pool size"); // R6

   AST_POOL_RESET_FULL: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (free_q == ALL_FREE)) else $error("pool not refilled by reset"); // R12
endmodule

// File: rtl/mem_cmd_accept.sv
module mem_cmd_accept
   import mca_pkg::*;
#(
   parameter int COL_W      = 10,
   parameter int BANK_W     = 3,
   parameter int ROW_W      = 14,
   parameter int NUM_RANKS  = 1,
   parameter int MAP        = 0,
   parameter int DEPTH      = 4,
   parameter int WPTR_COUNT = 3,
   parameter int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   parameter int ADDR_W     = COL_W + BANK_W + ROW_W + ((NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 0)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_en,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_urgent,
   output logic              cmd_rdy,
   input  logic              cal_done,
   input  logic              rd_buf_full,
   input  logic              periodic_rd,
   input  logic              wptr_release,
   output logic              q_valid,
   input  logic              q_pop,
   output logic              q_is_read,
   output logic              q_urgent,
   output logic [RANK_W-1:0] q_rank,
   output logic [BANK_W-1:0] q_bank,
   output logic [ROW_W-1:0]  q_row,
   output logic [COL_W-1:0]  q_col
);
   localparam int ENTRY_W = 2 + RANK_W + BANK_W + ROW_W + COL_W;

   if (COL_W < 1 || BANK_W < 1 || ROW_W < 1) begin : g_bad_fields
      $error("mem_cmd_accept: field widths must be positive");
   end

   logic              is_rd, is_wr, resource_ok, accept;
   logic              slots_full, slots_empty, wptr_avail;
   logic [RANK_W-1:0] d_rank;
   logic [BANK_W-1:0] d_bank;
   logic [ROW_W-1:0]  d_row;
   logic [COL_W-1:0]  d_col;
   logic [ENTRY_W-1:0] push_word, head_word;

   assign is_rd = (cmd_op == OP_READ);
   assign is_wr = (cmd_op == OP_WRITE);

   always_comb begin
      resource_ok = 1'b0;
      if (is_rd) begin
         resource_ok = !rd_buf_full;
      end else if (is_wr) begin
         resource_ok = wptr_avail;
      end
   end

   assign cmd_rdy = cal_done && !periodic_rd && !slots_full && resource_ok;
   assign accept  = cmd_en && cmd_rdy;

   mca_addr_split #(
      .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .NUM_RANKS(NUM_RANKS),
      .MAP(MAP), .ADDR_W(ADDR_W), .RANK_W(RANK_W)
   ) u_split (
      .addr(cmd_addr), .rank(d_rank), .bank(d_bank), .row(d_row), .col(d_col)
   );

   assign push_word = {cmd_urgent, is_rd, d_rank, d_bank, d_row, d_col};

   mca_slot_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_slots (
      .clk(clk), .rst(rst), .push(accept), .din(push_word), .pop(q_pop),
      .dout(head_word), .empty(slots_empty), .full(slots_full)
   );

   mca_wptr_pool #(.COUNT(WPTR_COUNT)) u_wptr (
      .clk(clk), .rst(rst), .take(accept && is_wr), .give(wptr_release),
      .any_free(wptr_avail)
   );

   assign q_valid = !slots_empty;
   assign {q_urgent, q_is_read, q_rank, q_bank, q_row, q_col} = head_word;

   AST_BAD_OP_REFUSED: assert property (@(posedge clk) disable iff (rst)
      !op_known(cmd_op) |-> !cmd_rdy) else $error("unknown op made ready"); // R1

   AST_ACCEPT_QUEUED: assert property (@(posedge clk) disable iff (rst)
      (cmd_en && cmd_rdy) |=> q_valid) else $error("accepted request not queued"); // R2

   AST_NO_RDY_UNCAL: assert property (@(posedge clk) disable iff (rst)
      !cal_done |-> !cmd_rdy) else $error("ready before calibration"); // R3

   AST_RD_BUF_BLOCK: assert property (@(posedge clk) disable iff (rst)
      (rd_buf_full && is_rd) |-> !cmd_rdy) else $error("read taken with full buffer"); // R5

   AST_PERIODIC_HOLD: assert property (@(posedge clk) disable iff (rst)
      periodic_rd |-> !cmd_rdy) else $error("ready during periodic read"); // R7

   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !q_valid) else $error("queue not empty after reset"); // R12
endmodule

// File: tb/sim_mem_cmd_accept.sv
module sim_mem_cmd_accept;
   localparam int COL_W = 10, BANK_W = 3, ROW_W = 14;
   localparam int AW0 = COL_W + BANK_W + ROW_W;
   localparam int AW1 = AW0 + 1;
   localparam logic [2:0] WR = 3'b000, RD = 3'b001;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0, fails = 0;

   logic rst, cmd_en, cmd_urgent, cal_done, rd_buf_full, periodic_rd, wptr_release, q_pop;
   logic [2:0] cmd_op;
   logic [AW0-1:0] cmd_addr;
   logic cmd_rdy, q_valid, q_is_read, q_urgent;
   logic [0:0] q_rank;
   logic [BANK_W-1:0] q_bank;
   logic [ROW_W-1:0] q_row;
   logic [COL_W-1:0] q_col;

   mem_cmd_accept u0 (
      .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_urgent(cmd_urgent), .cmd_rdy(cmd_rdy), .cal_done(cal_done),
      .rd_buf_full(rd_buf_full), .periodic_rd(periodic_rd), .wptr_release(wptr_release),
      .q_valid(q_valid), .q_pop(q_pop), .q_is_read(q_is_read), .q_urgent(q_urgent),
      .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row), .q_col(q_col)
   );

   logic b_en, b_rdy, b_valid, b_is_read, b_urgent;
   logic [AW1-1:0] b_addr;
   logic [0:0] b_rank;
   logic [BANK_W-1:0] b_bank;
   logic [ROW_W-1:0] b_row;
   logic [COL_W-1:0] b_col;

   mem_cmd_accept #(.NUM_RANKS(2), .MAP(1)) u1 (
      .clk(clk), .rst(rst), .cmd_en(b_en), .cmd_op(RD), .cmd_addr(b_addr),
      .cmd_urgent(1'b0), .cmd_rdy(b_rdy), .cal_done(1'b1), .rd_buf_full(1'b0),
      .periodic_rd(1'b0), .wptr_release(1'b0), .q_valid(b_valid), .q_pop(1'b0),
      .q_is_read(b_is_read), .q_urgent(b_urgent), .q_rank(b_rank), .q_bank(b_bank),
      .q_row(b_row), .q_col(b_col)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic accept(input logic [2:0] op, input logic [AW0-1:0] a, input logic urg);
      cmd_op = op; cmd_addr = a; cmd_urgent = urg; cmd_en = 1'b1;
      #1 check("R2 ready for accepted request", 32'(cmd_rdy), 1);
      @(posedge clk); #1 cmd_en = 1'b0;
   endtask

   task automatic pop_one();
      q_pop = 1'b1; @(posedge clk); #1 q_pop = 1'b0;
   endtask

   task automatic probe(input string tag, input logic [2:0] op, input logic exp);
      cmd_op = op; #1 check(tag, 32'(cmd_rdy), 32'(exp));
   endtask

   // {cal_done, rd_buf_full, periodic_rd, op[2:0], expected ready}
   localparam int NV = 12;
   localparam logic [6:0] VEC [NV] = '{
      {3'b100, RD, 1'b1}, {3'b100, WR, 1'b1},   // R1 both codes pass
      {3'b000, RD, 1'b0}, {3'b000, WR, 1'b0},   // R3
      {3'b110, RD, 1'b0}, {3'b110, WR, 1'b1},   // R5
      {3'b101, RD, 1'b0}, {3'b101, WR, 1'b0},   // R7
      {3'b100, 3'b010, 1'b0}, {3'b100, 3'b111, 1'b0},
      {3'b100, 3'b100, 1'b0}, {3'b110, 3'b011, 1'b0}  // R1 unknown codes
   };

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [AW0-1:0] wa [3];
      logic [AW0-1:0] ra, rb;
      logic [AW1-1:0] ba;
      logic ug [3];
      rst = 1; cmd_en = 0; cmd_op = RD; cmd_addr = '0; cmd_urgent = 0;
      cal_done = 0; rd_buf_full = 0; periodic_rd = 0; wptr_release = 0; q_pop = 0;
      b_en = 0; b_addr = '0;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      @(negedge clk);
      check("R12 queue empty after reset", 32'(q_valid), 0);

      for (int i = 0; i < NV; i++) begin
         @(posedge clk); #1;
         {cal_done, rd_buf_full, periodic_rd, cmd_op} = VEC[i][6:1];
         @(negedge clk);
         check($sformatf("R1/R3/R5/R7 ready gate vector %0d", i), 32'(cmd_rdy), 32'(VEC[i][0]));
      end
      @(posedge clk); #1;
      cal_done = 1; rd_buf_full = 0; periodic_rd = 0;

      // R8 R10: decode with row-bank-column order, one rank
      ra = 27'h5A3_C6B1;
      accept(RD, ra, 1'b1);
      check("R2 valid after accept", 32'(q_valid), 1);
      check("R11 read flag", 32'(q_is_read), 1);
      check("R11 urgent flag", 32'(q_urgent), 1);
      check("R8 column", 32'(q_col), 32'(ra[0 +: COL_W]));
      check("R8 bank", 32'(q_bank), 32'(ra[COL_W +: BANK_W]));
      check("R8 row", 32'(q_row), 32'(ra[COL_W + BANK_W +: ROW_W]));
      check("R10 single rank is zero", 32'(q_rank), 0);
      pop_one();
      check("R2 queue empty after pop", 32'(q_valid), 0);

      // R6: use up all write pointers
      wa[0] = 27'h123_4567; wa[1] = 27'h7FE_DCBA; wa[2] = 27'h0AB_CDEF;
      ug[0] = 1'b1; ug[1] = 1'b0; ug[2] = 1'b1;
      for (int i = 0; i < 3; i++) accept(WR, wa[i], ug[i]);
      probe("R6 write blocked with no pointer", WR, 1'b0);
      probe("R6 read unaffected by pointers", RD, 1'b1);
      wptr_release = 1; @(posedge clk); #1 wptr_release = 0;
      probe("R6 write ready after release", WR, 1'b1);

      // R4: fill remaining slot
      rb = 27'h3C0_FFEE;
      accept(RD, rb, 1'b0);
      probe("R4 write blocked when slots full", WR, 1'b0);
      probe("R4 read blocked when slots full", RD, 1'b0);

      // R11: order and flags
      for (int i = 0; i < 3; i++) begin
         check("R11 head valid", 32'(q_valid), 1);
         check("R11 write flag", 32'(q_is_read), 0);
         check("R11 urgent order", 32'(q_urgent), 32'(ug[i]));
         check("R11 column order", 32'(q_col), 32'(wa[i][0 +: COL_W]));
         pop_one();
         if (i == 0) probe("R4 ready after pop", RD, 1'b1);
      end
      check("R11 last entry is read", 32'(q_is_read), 1);
      check("R11 last row", 32'(q_row), 32'(rb[COL_W + BANK_W +: ROW_W]));
      pop_one();

      // R2: refused request not queued
      cal_done = 0; cmd_op = RD; cmd_en = 1;
      repeat (2) @(posedge clk);
      #1 cmd_en = 0; cal_done = 1;
      @(negedge clk);
      check("R2 refused request not queued", 32'(q_valid), 0);

      // R12: reset frees pointers and empties queue (one pointer free now)
      @(posedge clk); #1;
      accept(WR, wa[0], 1'b0);
      probe("R6 last pointer used", WR, 1'b0);
      rst = 1; @(posedge clk); #1 rst = 0;
      @(negedge clk);
      check("R12 queue empty after reset", 32'(q_valid), 0);
      probe("R12 pointers freed by reset", WR, 1'b1);
      for (int i = 0; i < 3; i++) accept(WR, wa[i], 1'b0);
      probe("R12 full pool after reset used", WR, 1'b0);

      // R9 R10: bank-row-column order, two ranks
      ba = 28'hB5A_3C6D;
      b_addr = ba; b_en = 1;
      #1 check("R2 second instance ready", 32'(b_rdy), 1);
      @(posedge clk); #1 b_en = 0;
      check("R2 second instance valid", 32'(b_valid), 1);
      check("R9 column", 32'(b_col), 32'(ba[0 +: COL_W]));
      check("R9 row", 32'(b_row), 32'(ba[COL_W +: ROW_W]));
      check("R9 bank", 32'(b_bank), 32'(ba[COL_W + ROW_W +: BANK_W]));
      check("R10 rank from top bit", 32'(b_rank), 32'(ba[AW1-1]));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule